// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from peripherals and presents one interrupt line to the processor. A master unit and a slave unit sit together. The slave's interrupt output feeds the master's cascade input, so fifteen request lines are usable. Each unit resolves a fixed priority among its lines. It tracks the lines already being serviced, so that only a line of strictly higher priority can interrupt a handler that is running.

When the processor pulses the acknowledge input, the master picks the winning line and marks it in service. The chosen unit places an 8-bit vector on the vector output for that cycle. This vector is a 5-bit base value for that unit followed by the 3-bit line number. If the cascade input wins, the master stays off the bus and the slave supplies its own vector in the same acknowledge cycle. Requests that arrive on the legacy line 2 are redirected to slave line 1, which is global line 9. Software ends a handler by pulsing the end-of-interrupt strobe of each unit involved.

Top module: `irqc_cascade`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `intr_o` and `vec_valid_o` are low, `vec_o` is zero and no line is in service.
- R2: Requests are registered on the clock. A request that is high before a rising edge can raise `intr_o` right after that edge, if it is eligible. `intr_o` stays high while any eligible request remains.
- R3: Lower indices have higher priority inside each unit. At the top level the service order is lines 0, 1, then slave lines 8 to 15 (occupying master slot 2), then lines 3 to 7.
- R4: In a cycle where `inta_i` is high and `intr_o` is high, `vec_valid_o` is high and `vec_o` = {base[4:0], line[2:0]} of the winner. In every other cycle `vec_valid_o` is low and `vec_o` is zero.
- R5: An acknowledge marks the winning line in service. A line is eligible only when no line of equal or higher priority in its unit is in service. So lower or equal lines are held off, and a higher line pre-empts and nests.
- R6: A pulse on a unit's end-of-interrupt strobe clears the highest-priority in-service line of that unit. If it coincides with an acknowledge, the clear is applied first.
- R7: When master slot 2 wins an acknowledge, the vector comes from the slave with the slave base. Master line 2 and the slave's winning line both become in service.
- R8: A request on `req_i[2]` acts as a request on slave line 1, so it yields the slave-base vector with line field 1.
- R9: An acknowledge while `intr_o` is low gives no vector and changes no in-service state. This covers a request that dropped before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Level requests; bits 15:8 slave lines, bit 2 redirected to slave line 1 |
| inta_i | input | 1 | Processor acknowledge, one-cycle pulse |
| eoi_master_i | input | 1 | End-of-interrupt strobe for the master unit |
| eoi_slave_i | input | 1 | End-of-interrupt strobe for the slave unit |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector on `vec_o` is valid this cycle |
| vec_o | output | 8 | Interrupt vector, zero when not valid |

## Verification
The assertions assume that acknowledge and end-of-interrupt are single-cycle pulses sampled on the clock. They also assume that an end-of-interrupt is not issued together with an acknowledge, except where the clear-first order is checked on its own. The directed phases therefore pulse each strobe for exactly one cycle. The pseudo-random phase draws acknowledge and strobe bits separately and keeps only the cases where at most one of them is set. This holds both the in-service bookkeeping and the assertions inside these assumptions, while the cycle-level model covers every combination of requests.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - IDX_W;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Lowest set index wins.
  function automatic pick_t first_set(input logic [LINES-1:0] v);
    pick_t p;
    p = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction

  // One-hot of the highest-priority (lowest index) set bit.
  function automatic logic [LINES-1:0] top_bit(input logic [LINES-1:0] v);
    return v & (~v + LINES'(1));
  endfunction

  function automatic logic [VEC_W-1:0] make_vec(input logic [BASE_W-1:0] base,
                                                input logic [IDX_W-1:0]  idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/irqc_req_stage.sv
module irqc_req_stage
  import irqc_pkg::*;
#(
  parameter int CASCADE_PIN  = 2,
  parameter int REDIRECT_PIN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] raw_i,
  output logic [LINES-1:0]   m_req_o,
  output logic [LINES-1:0]   s_req_o
);
  logic [LINES-1:0] m_d, s_d;

  always_comb begin
    m_d = raw_i[LINES-1:0];
    m_d[CASCADE_PIN] = 1'b0;
    s_d = raw_i[2*LINES-1:LINES];
    s_d[REDIRECT_PIN] = raw_i[LINES + REDIRECT_PIN] | raw_i[CASCADE_PIN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_req_o <= '0;
      s_req_o <= '0;
    end else begin
      m_req_o <= m_d;
      s_req_o <= s_d;
    end
  end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
  import irqc_pkg::*;
#(
  parameter logic [BASE_W-1:0] BASE = BASE_W'(4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             intr_o,
  output logic [IDX_W-1:0] win_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [LINES-1:0] isr_q, isr_d, open_line, eligible;
  pick_t            pick;
  logic             ack_taken;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_open
      assign open_line[i] = ~|isr_q[i:0];
    end
  endgenerate

  assign eligible  = req_i & open_line;
  assign pick      = first_set(eligible);
  assign intr_o    = pick.hit;
  assign win_o     = pick.idx;
  assign vec_o     = make_vec(BASE, pick.idx);
  assign ack_taken = ack_i & pick.hit;

  always_comb begin
    isr_d = isr_q;
    if (eoi_i) isr_d = isr_d & ~top_bit(isr_q);
    if (ack_taken) isr_d[pick.idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assert_winner_not_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> !isr_q[win_o]);

  assert_ack_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && intr_o && !eoi_i) |=> isr_q[$past(win_o)]);

  assert_eoi_drops_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && (|isr_q)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  assert_isr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ack_i && intr_o) && !eoi_i) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
  import irqc_pkg::*;
#(
  parameter logic [BASE_W-1:0] MASTER_BASE = BASE_W'(4),
  parameter logic [BASE_W-1:0] SLAVE_BASE  = BASE_W'(5),
  parameter int                CASCADE_PIN = 2,
  parameter int                REDIRECT_PIN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] req_i,
  input  logic               inta_i,
  input  logic               eoi_master_i,
  input  logic               eoi_slave_i,
  output logic               intr_o,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [LINES-1:0] m_req_s, s_req_s, m_req;
  logic             s_intr, m_intr, s_ack, cascade_win;
  logic [IDX_W-1:0] m_win, s_win;
  logic [VEC_W-1:0] m_vec, s_vec;

  irqc_req_stage #(.CASCADE_PIN(CASCADE_PIN), .REDIRECT_PIN(REDIRECT_PIN)) u_stage (
    .clk(clk), .rst_n(rst_n), .raw_i(req_i), .m_req_o(m_req_s), .s_req_o(s_req_s));

  irqc_unit #(.BASE(SLAVE_BASE)) u_slave (
    .clk(clk), .rst_n(rst_n), .req_i(s_req_s), .ack_i(s_ack), .eoi_i(eoi_slave_i),
    .intr_o(s_intr), .win_o(s_win), .vec_o(s_vec));

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_mreq
      if (i == CASCADE_PIN) begin : g_link
        assign m_req[i] = s_intr;
      end else begin : g_pass
        assign m_req[i] = m_req_s[i];
      end
    end
  endgenerate

  irqc_unit #(.BASE(MASTER_BASE)) u_master (
    .clk(clk), .rst_n(rst_n), .req_i(m_req), .ack_i(inta_i), .eoi_i(eoi_master_i),
    .intr_o(m_intr), .win_o(m_win), .vec_o(m_vec));

  assign cascade_win = m_intr && (m_win == IDX_W'(CASCADE_PIN));
  assign s_ack       = inta_i && cascade_win;
  assign intr_o      = m_intr;
  assign vec_valid_o = inta_i && m_intr;
  assign vec_o       = !vec_valid_o ? '0 : (cascade_win ? s_vec : m_vec);

  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_o == '0));

  assert_slave_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && cascade_win) |-> (vec_o[VEC_W-1:IDX_W] == SLAVE_BASE && s_intr));

  assert_no_ack_no_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && !intr_o) |-> !vec_valid_o);
endmodule

// File: tb/irqc_cascade_test.sv
module irqc_cascade_test;
  localparam logic [4:0] MB = 5'h04;
  localparam logic [4:0] SB = 5'h05;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        inta = 1'b0, eoi_m = 1'b0, eoi_s = 1'b0;
  logic        intr, vvalid;
  logic [7:0]  vec;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  irqc_cascade #(.MASTER_BASE(MB), .SLAVE_BASE(SB)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .inta_i(inta),
    .eoi_master_i(eoi_m), .eoi_slave_i(eoi_s),
    .intr_o(intr), .vec_valid_o(vvalid), .vec_o(vec));

  // Reference state
  bit [15:0] smp;
  bit [7:0]  m_isr, s_isr;

  function automatic int best(bit [7:0] r, bit [7:0] isr);
    int h = 8;
    for (int i = 7; i >= 0; i--) if (isr[i]) h = i;
    for (int i = 0; i < h; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic bit [7:0] clear_top(bit [7:0] isr);
    for (int i = 0; i < 8; i++) if (isr[i]) begin isr[i] = 0; return isr; end
    return isr;
  endfunction

  int s_w, m_w;
  bit exp_intr, exp_valid;
  bit [7:0] exp_vec;

  task automatic evaluate();
    bit [7:0] sr, mr;
    sr = smp[15:8];
    sr[1] = sr[1] | smp[2];
    s_w = best(sr, s_isr);
    mr = smp[7:0];
    mr[2] = (s_w >= 0);
    m_w = best(mr, m_isr);
    exp_intr  = (m_w >= 0);
    exp_valid = inta && exp_intr;
    if (!exp_valid)  exp_vec = 8'h00;
    else if (m_w == 2) exp_vec = {SB, 3'(s_w)};
    else exp_vec = {MB, 3'(m_w)};
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      smp = '0; m_isr = '0; s_isr = '0;
    end else begin
      evaluate();
      if (eoi_m) m_isr = clear_top(m_isr);
      if (eoi_s) s_isr = clear_top(s_isr);
      if (exp_valid) begin
        m_isr[m_w] = 1'b1;
        if (m_w == 2) s_isr[s_w] = 1'b1;
      end
      smp = req;
    end
  end

  task automatic check(string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, expv, $time);
    end
  endtask

  task automatic compare();
    evaluate();
    check("intr_o", int'(intr), int'(exp_intr));
    check("vec_valid_o", int'(vvalid), int'(exp_valid));
    check("vec_o", int'(vec), int'(exp_vec));
  endtask

  task automatic step(logic [15:0] r, logic a = 0, logic em = 0, logic es = 0);
    @(negedge clk);
    req = r; inta = a; eoi_m = em; eoi_s = es;
    #2 compare();
  endtask

  task automatic expect_vec(string tag, logic [7:0] v);
    phase = tag;
    checks++;
    if (!(vvalid && vec == v)) begin
      errors++;
      $display("FAIL %s explicit vector: actual %0h/%0b expected %0h/1", tag, vec, vvalid, v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 50000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int lfsr = 32'h1ace;
    // R1: reset state, then first cycle after release
    phase = "R1";
    repeat (3) begin
      @(negedge clk); req = 16'h00f0; #2;
      check("intr_o in reset", int'(intr), 0);
      check("vec_o in reset", int'(vec), 0);
    end
    @(negedge clk); rst_n = 1'b1; req = '0; #2 compare();
    step('0);
    // R2: sampling latency
    phase = "R2";
    step(16'h0020);
    step(16'h0020);
    // R4: vector for master line 5, then clear
    phase = "R4";
    step(16'h0020, 1);
    expect_vec("R4", {MB, 3'd5});
    step(16'h0000, 0, 1);
    step(16'h0000);
    // R3: simultaneous master lines 3 and 6, and slave vs line 3
    phase = "R3";
    step(16'h0048); step(16'h0048, 1);
    expect_vec("R3", {MB, 3'd3});
    step(16'h0048, 0, 1);
    step(16'h1008); step(16'h1008, 1);
    expect_vec("R3", {SB, 3'd4});
    step(16'h0000, 0, 1, 1); step(16'h0000);
    // R5: hold-off of equal/lower, pre-emption by higher
    phase = "R5";
    step(16'h0040); step(16'h0040, 1);
    step(16'h00c0); step(16'h00c0);
    step(16'h00c2); step(16'h00c2, 1);
    expect_vec("R5", {MB, 3'd1});
    step(16'h00c2); step(16'h00c2);
    // R6: each strobe clears the highest-priority in-service line
    phase = "R6";
    step(16'h00c2, 0, 1); step(16'h00c0);
    step(16'h00c0, 0, 1); step(16'h00c0);
    step(16'h0080, 1);
    step(16'h0000, 1, 1);
    step(16'h0000, 0, 1); step(16'h0000);
    // R7: cascade acknowledge
    phase = "R7";
    step(16'h8000); step(16'h8000, 1);
    expect_vec("R7", {SB, 3'd7});
    step(16'h8100); step(16'h8100);
    step(16'h0000, 0, 1, 1); step(16'h0000, 0, 0, 1); step(16'h0000);
    // R8: legacy line 2 redirected to slave line 1
    phase = "R8";
    step(16'h0004); step(16'h0004, 1);
    expect_vec("R8", {SB, 3'd1});
    step(16'h0000, 0, 1, 1); step(16'h0000);
    // R9: dropped request, then bare acknowledge
    phase = "R9";
    step(16'h0010); step(16'h0000); step(16'h0000, 1);
    step(16'h0010); step(16'h0010, 1);
    expect_vec("R9", {MB, 3'd4});
    step(16'h0000, 0, 1); step(16'h0000);
    // Mixed pseudo-random phase (R2..R9), one strobe at a time
    phase = "R3";
    for (int k = 0; k < 600; k++) begin
      logic [15:0] r;
      logic a, em, es;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r  = lfsr[15:0] & lfsr[31:16];
      a  = (lfsr[3:0] == 4'h1);
      em = (lfsr[6:4] == 3'h2) && !a;
      es = (lfsr[9:7] == 3'h3) && !a && !em;
      step(r, a, em, es);
    end
    finish_run();
  end
endmodule